// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between the address-generation stage of a small 8-bit core and its data-side storage. Each cycle it may take one access request. A direct request names a location by an in-bank offset, and the current bank number supplies the bank. An indirect request carries a 16-bit pointer instead. That pointer can address the banked space, a contiguous linear window over the general-purpose RAM of all banks, or program memory.

Every accepted request is decoded to exactly one target region. The block then presents a one-hot region select and the physical address inside that region's own storage. It also forwards a write strobe, which is suppressed for targets that cannot be written. A read-return mux picks the byte of the selected region and forces zero for unimplemented space. Program-memory reads take one extra cycle. During that cycle the block refuses new requests.

Within each 128-byte bank the layout is fixed. The first 12 bytes are core registers and the next 20 are peripheral registers. Then come 80 bytes of general-purpose RAM, and the last 16 bytes are common RAM. The core registers and the common RAM are the same storage in every bank. General-purpose RAM exists only in the lowest `GPR_BANKS` banks.

Top module: `bdm_mapper`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A direct request uses bank `bank_sel` and offset `req_offset`. Offsets 0x00..0x0B select core registers (region bit 0), with `out_addr` equal to the offset, in every bank. The result appears with `out_valid` one cycle after acceptance.
- R3: Offsets 0x0C..0x1F select peripheral registers (region bit 1), with `out_addr` = bank*20 + offset - 12.
- R4: Offsets 0x20..0x6F select general-purpose RAM (region bit 2), with `out_addr` = bank*80 + offset - 32, but only when bank < `GPR_BANKS` (default 6). In higher banks these offsets are unimplemented.
- R5: Offsets 0x70..0x7F select common RAM (region bit 3), with `out_addr` = offset - 0x70, in every bank.
- R6: For an indirect pointer in 0x0000..0x0FFF, bits 11:7 give the bank and bits 6:0 give the offset, with the same decode as R2..R5. Pointers in 0x1000..0x1FFF and 0x3000..0x7FFF are unimplemented (region bit 5, `out_addr` 0).
- R7: An indirect pointer 0x2000+n maps to general-purpose RAM with `out_addr` = n when n < `GPR_BANKS`*80. For larger n it is unimplemented.
- R8: An indirect pointer with bit 15 set targets program memory (region bit 4) with `out_addr` = pointer bits `PM_AW`-1:0, so higher addresses wrap. The result appears two cycles after acceptance, and `req_ready` is 0 in the cycle between.
- R9: `out_wr` equals `req_write` for core, peripheral, general-purpose and common targets, and is 0 for program-memory and unimplemented targets.
- R10: While `out_valid` is high, `rd_data` is the read byte of the selected region. For program memory it is bits 7:0 of `pm_rd`, and for unimplemented space it is 0.
- R11: A request presented while `req_ready` is 0 is dropped and produces no result.
- R12: Every result has exactly one bit of `out_region` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | Request is a write |
| req_indirect | input | 1 | Use pointer instead of bank/offset |
| bank_sel | input | BANK_W | Current bank number |
| req_offset | input | 7 | In-bank offset for direct requests |
| req_ptr | input | 16 | Pointer for indirect requests |
| req_ready | output | 1 | Block can accept a request this cycle |
| core_rd | input | 8 | Read byte from core registers |
| periph_rd | input | 8 | Read byte from peripheral registers |
| gpr_rd | input | 8 | Read byte from general-purpose RAM |
| common_rd | input | 8 | Read byte from common RAM |
| pm_rd | input | 14 | Program-memory word |
| out_valid | output | 1 | Decoded result present |
| out_region | output | 6 | One-hot target region |
| out_addr | output | PA_W | Physical address inside the region |
| out_wr | output | 1 | Write strobe to the region |
| rd_data | output | 8 | Read byte returned to the core |

## Verification
The hardest situation to reach is a request arriving during the program-memory wait cycle. It exists for only one cycle, and only right after a pointer with bit 15 set. The bench issues a program-memory read and, on the very next cycle, drives a second, valid-looking direct request while the block is not ready. The scoreboard then expects only the program-memory result and flags any extra output. The linear-window edge (n = 479 against n = 480) and the banks just above the last one with general-purpose RAM are hit deliberately, as is the pointer wrap from 0xFFFF.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int OFF_W       = 7;
  localparam int CORE_N      = 12;
  localparam int PERIPH_N    = 20;
  localparam int GPR_N       = 80;
  localparam int COMMON_N    = 16;
  localparam int PERIPH_BASE = CORE_N;
  localparam int GPR_BASE    = CORE_N + PERIPH_N;
  localparam int COMMON_BASE = GPR_BASE + GPR_N;

  // one-hot region bit positions
  localparam int RG_CORE   = 0;
  localparam int RG_PERIPH = 1;
  localparam int RG_GPR    = 2;
  localparam int RG_COMMON = 3;
  localparam int RG_PM     = 4;
  localparam int RG_UNIMPL = 5;
  localparam int RG_N      = 6;

  // pointer high nibble selecting the linear RAM window
  localparam logic [3:0] LIN_TAG = 4'h2;
endpackage

// File: rtl/bdm_bank_dec.sv
module bdm_bank_dec
  import bdm_pkg::*;
#(
  parameter int NBANKS    = 32,
  parameter int GPR_BANKS = 6,
  parameter int PA_W      = 12,
  localparam int BANK_W   = $clog2(NBANKS)
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  off,
  output logic [RG_N-1:0]   region,
  output logic [PA_W-1:0]   addr
);
  int b, o;

  always_comb begin
    b      = int'(bank);
    o      = int'(off);
    region = '0;
    addr   = '0;
    if (o < PERIPH_BASE) begin
      region[RG_CORE] = 1'b1;
      addr            = PA_W'(o);
    end else if (o < GPR_BASE) begin
      region[RG_PERIPH] = 1'b1;
      addr              = PA_W'(b * PERIPH_N + o - PERIPH_BASE);
    end else if (o < COMMON_BASE) begin
      if (b < GPR_BANKS) begin
        region[RG_GPR] = 1'b1;
        addr           = PA_W'(b * GPR_N + o - GPR_BASE);
      end else begin
        region[RG_UNIMPL] = 1'b1;
      end
    end else begin
      region[RG_COMMON] = 1'b1;
      addr              = PA_W'(o - COMMON_BASE);
    end
  end
endmodule

// File: rtl/bdm_lin_dec.sv
module bdm_lin_dec
  import bdm_pkg::*;
#(
  parameter int NBANKS    = 32,
  parameter int GPR_BANKS = 6,
  localparam int BANK_W   = $clog2(NBANKS),
  localparam int LIN_SIZE = GPR_BANKS * GPR_N
) (
  input  logic [11:0]       idx,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output logic [OFF_W-1:0]  off
);
  int n;

  always_comb begin
    n    = int'(idx);
    hit  = (n < LIN_SIZE);
    bank = '0;
    off  = '0;
    if (hit) begin
      bank = BANK_W'(n / GPR_N);
      off  = OFF_W'(GPR_BASE + n % GPR_N);
    end
  end
endmodule

// File: rtl/bdm_rd_mux.sv
module bdm_rd_mux
  import bdm_pkg::*;
(
  input  logic [RG_N-1:0] region,
  input  logic [7:0]      core_rd,
  input  logic [7:0]      periph_rd,
  input  logic [7:0]      gpr_rd,
  input  logic [7:0]      common_rd,
  input  logic [13:0]     pm_rd,
  output logic [7:0]      rd_data
);
  logic [7:0] lane   [RG_N];
  logic [7:0] masked [RG_N];

  assign lane[RG_CORE]   = core_rd;
  assign lane[RG_PERIPH] = periph_rd;
  assign lane[RG_GPR]    = gpr_rd;
  assign lane[RG_COMMON] = common_rd;
  assign lane[RG_PM]     = pm_rd[7:0];
  assign lane[RG_UNIMPL] = 8'h00;

  for (genvar g = 0; g < RG_N; g++) begin : g_lane
    assign masked[g] = region[g] ? lane[g] : 8'h00;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < RG_N; i++) rd_data = rd_data | masked[i];
  end
endmodule

// File: rtl/bdm_mapper.sv
module bdm_mapper
  import bdm_pkg::*;
#(
  parameter int NBANKS    = 32,
  parameter int GPR_BANKS = 6,
  parameter int PM_AW     = 12,
  localparam int BANK_W   = $clog2(NBANKS),
  localparam int PA_W     = (PM_AW > 12) ? PM_AW : 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [6:0]        req_offset,
  input  logic [15:0]       req_ptr,
  output logic              req_ready,
  input  logic [7:0]        core_rd,
  input  logic [7:0]        periph_rd,
  input  logic [7:0]        gpr_rd,
  input  logic [7:0]        common_rd,
  input  logic [13:0]       pm_rd,
  output logic              out_valid,
  output logic [5:0]        out_region,
  output logic [PA_W-1:0]   out_addr,
  output logic              out_wr,
  output logic [7:0]        rd_data
);
  localparam int HI_LSB = 7 + BANK_W;

  // pointer classification
  logic is_pm, is_lin, is_banked;
  logic lin_hit;
  logic [BANK_W-1:0] lin_bank, dec_bank;
  logic [OFF_W-1:0]  lin_off, dec_off;
  logic [RG_N-1:0]   bank_region, dec_region;
  logic [PA_W-1:0]   bank_addr, dec_addr;

  assign is_pm     = req_indirect && req_ptr[15];
  assign is_lin    = req_indirect && !req_ptr[15] && (req_ptr[15:12] == LIN_TAG);
  assign is_banked = !req_indirect || (req_ptr[15:HI_LSB] == '0);

  bdm_lin_dec #(.NBANKS(NBANKS), .GPR_BANKS(GPR_BANKS)) u_lin (
    .idx (req_ptr[11:0]),
    .hit (lin_hit),
    .bank(lin_bank),
    .off (lin_off)
  );

  always_comb begin
    if (!req_indirect) begin
      dec_bank = bank_sel;
      dec_off  = req_offset;
    end else if (is_lin) begin
      dec_bank = lin_bank;
      dec_off  = lin_off;
    end else begin
      dec_bank = req_ptr[7 +: BANK_W];
      dec_off  = req_ptr[6:0];
    end
  end

  bdm_bank_dec #(.NBANKS(NBANKS), .GPR_BANKS(GPR_BANKS), .PA_W(PA_W)) u_bank (
    .bank  (dec_bank),
    .off   (dec_off),
    .region(bank_region),
    .addr  (bank_addr)
  );

  always_comb begin
    dec_region = bank_region;
    dec_addr   = bank_addr;
    if (!(is_banked || (is_lin && lin_hit))) begin
      dec_region             = '0;
      dec_region[RG_UNIMPL]  = 1'b1;
      dec_addr               = '0;
    end
  end

  // pipeline and program-memory wait state
  logic             pm_pend;
  logic [PA_W-1:0]  pm_addr;
  logic             accept;

  assign req_ready = !pm_pend;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_pend    <= 1'b0;
      pm_addr    <= '0;
      out_valid  <= 1'b0;
      out_region <= '0;
      out_addr   <= '0;
      out_wr     <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_wr    <= 1'b0;
      if (pm_pend) begin
        pm_pend           <= 1'b0;
        out_valid         <= 1'b1;
        out_region        <= '0;
        out_region[RG_PM] <= 1'b1;
        out_addr          <= pm_addr;
      end else if (accept) begin
        if (is_pm) begin
          pm_pend <= 1'b1;
          pm_addr <= PA_W'(req_ptr[PM_AW-1:0]);
        end else begin
          out_valid  <= 1'b1;
          out_region <= dec_region;
          out_addr   <= dec_addr;
          out_wr     <= req_write && !dec_region[RG_UNIMPL];
        end
      end
    end
  end

  bdm_rd_mux u_rd (
    .region   (out_region),
    .core_rd  (core_rd),
    .periph_rd(periph_rd),
    .gpr_rd   (gpr_rd),
    .common_rd(common_rd),
    .pm_rd    (pm_rd),
    .rd_data  (rd_data)
  );

  // assertions
  p_region_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_region) == 1);

  p_valid_origin_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(accept) || $past(pm_pend)));

  p_pm_after_wait_r8: assert property (@(posedge clk) disable iff (rst)
    pm_pend |=> (out_valid && out_region[RG_PM]));

  p_pm_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_region[RG_PM]) |-> !out_wr);

  p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_region[RG_UNIMPL]) |-> (rd_data == 8'h00 && out_addr == '0 && !out_wr));

  p_busy_after_pm_r11: assert property (@(posedge clk) disable iff (rst)
    (accept && is_pm) |=> !req_ready);
endmodule

// File: tb/tb_bdm_mapper.sv
module tb_bdm_mapper;
  localparam int BANK_W = 5;
  localparam int PA_W   = 12;
  localparam int GPRB   = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_indirect = 0;
  logic [BANK_W-1:0] bank_sel = '0;
  logic [6:0]  req_offset = '0;
  logic [15:0] req_ptr = '0;
  logic req_ready, out_valid, out_wr;
  logic [5:0] out_region;
  logic [PA_W-1:0] out_addr;
  logic [7:0] rd_data;
  logic [7:0]  core_rd = 8'hA1, periph_rd = 8'hB2, gpr_rd = 8'hC3, common_rd = 8'hD4;
  logic [13:0] pm_rd = 14'h3E5A;

  int n_chk = 0, n_bad = 0;
  logic [26:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  bdm_mapper dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_indirect(req_indirect), .bank_sel(bank_sel), .req_offset(req_offset),
    .req_ptr(req_ptr), .req_ready(req_ready), .core_rd(core_rd),
    .periph_rd(periph_rd), .gpr_rd(gpr_rd), .common_rd(common_rd),
    .pm_rd(pm_rd), .out_valid(out_valid), .out_region(out_region),
    .out_addr(out_addr), .out_wr(out_wr), .rd_data(rd_data));

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // expected {region6, addr12, wr1, rd8}
  function automatic logic [26:0] bank_model(int b, int o, logic wr);
    int rg; int a; logic [7:0] rd;
    a = 0;
    if (o < 12) begin rg = 0; a = o; end
    else if (o < 32) begin rg = 1; a = b*20 + o - 12; end
    else if (o < 112) begin
      if (b < GPRB) begin rg = 2; a = b*80 + o - 32; end else rg = 5;
    end else begin rg = 3; a = o - 112; end
    case (rg)
      0: rd = 8'hA1; 1: rd = 8'hB2; 2: rd = 8'hC3; 3: rd = 8'hD4; default: rd = 8'h00;
    endcase
    return {6'(1 << rg), 12'(a), (wr && rg != 5), rd};
  endfunction

  function automatic logic [26:0] ptr_model(logic [15:0] p, logic wr);
    int n;
    if (p[15]) return {6'b010000, p[11:0], 1'b0, 8'h5A};
    if (p[15:12] == 4'h0) return bank_model(int'(p[11:7]), int'(p[6:0]), wr);
    if (p[15:12] == 4'h2) begin
      n = int'(p[11:0]);
      if (n < GPRB*80) return {6'b000100, 12'(n), wr, 8'hC3};
    end
    return {6'b100000, 12'h0, 1'b0, 8'h00};
  endfunction

  task automatic direct(string tag, int b, int o, logic wr);
    req_valid = 1; req_indirect = 0; req_write = wr;
    bank_sel = BANK_W'(b); req_offset = 7'(o);
    exp_q.push_back(bank_model(b, o, wr)); tag_q.push_back(tag);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic indirect(string tag, logic [15:0] p, logic wr);
    req_valid = 1; req_indirect = 1; req_write = wr; req_ptr = p;
    exp_q.push_back(ptr_model(p, wr)); tag_q.push_back(tag);
    @(negedge clk); req_valid = 0;
    if (p[15]) begin
      check("R8 ready low in wait cycle", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check("R11 unexpected result", 32'(out_region), 32'd0);
        end else begin
          logic [26:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check({t, " region"}, 32'(out_region), 32'(e[26:21]));
          check({t, " addr"},   32'(out_addr),   32'(e[20:9]));
          check({t, " R9 wr"},  32'(out_wr),     32'(e[8]));
          check({t, " R10 rd"}, 32'(rd_data),    32'(e[7:0]));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(out_valid), 32'd0);
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    rst = 0;
    @(negedge clk);
    check("R1 valid after reset", 32'(out_valid), 32'd0);
    check("R1 ready after reset", 32'(req_ready), 32'd1);

    // direct accesses across every bank and every region edge
    for (int b = 0; b < 32; b++) begin
      direct("R2 core",    b, 8'h00, b[0]);
      direct("R2 core",    b, 8'h0B, 1'b1);
      direct("R3 periph",  b, 8'h0C, 1'b0);
      direct("R3 periph",  b, 8'h1F, 1'b1);
      direct("R4 gpr",     b, 8'h20, 1'b1);
      direct("R4 gpr",     b, 8'h6F, 1'b0);
      direct("R5 common",  b, 8'h70, 1'b1);
      direct("R5 common",  b, 8'h7F, 1'b0);
    end
    // back-to-back with no idle done above; now indirect banked
    indirect("R6 banked",   16'h0000, 1'b0);
    indirect("R6 banked",   16'h02A5, 1'b1);
    indirect("R6 banked",   16'h0FFF, 1'b1);
    indirect("R6 banked",   16'h0330, 1'b1);
    indirect("R6 unimpl",   16'h1234, 1'b1);
    indirect("R6 unimpl",   16'h7FFF, 1'b0);
    indirect("R6 unimpl",   16'h3000, 1'b1);
    // linear window
    indirect("R7 linear",   16'h2000, 1'b1);
    indirect("R7 linear",   16'h2055, 1'b0);
    indirect("R7 linear",   16'h2000 + 16'd479, 1'b1);
    indirect("R7 beyond",   16'h2000 + 16'd480, 1'b1);
    indirect("R7 beyond",   16'h2FFF, 1'b0);
    // program memory
    indirect("R8 pm",       16'h8123, 1'b0);
    indirect("R8 pm wrap",  16'hFFFF, 1'b0);
    indirect("R9 pm write", 16'h9ABC, 1'b1);
    direct("R2 after pm", 3, 8'h05, 1'b1);

    // R11: request during wait cycle is dropped
    req_valid = 1; req_indirect = 1; req_write = 0; req_ptr = 16'h8042;
    exp_q.push_back(ptr_model(16'h8042, 1'b0)); tag_q.push_back("R11 pm");
    @(negedge clk);
    check("R11 ready low", 32'(req_ready), 32'd0);
    req_indirect = 0; req_write = 1; bank_sel = 5'd2; req_offset = 7'h10;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule